// File: doc/BRIEF.md
# Quadrature to Up/Down Pulse Converter

This block turns the two phase-shifted channels of an incremental encoder into two separate active-low pulse trains: one for forward motion and one for reverse motion. A standard up/down counter can take these trains directly. The encoder channels and the index track are all sampled by the system clock. Each one passes through a synchronizer and a stability filter, which together reject short dither before any edge is decoded.

Two select pins set the resolution to one, two or four pulses per encoder cycle. A level output reports the present direction of motion. An active-low reference pulse marks the index position, and it is aligned to one particular quadrature edge in each direction. The width of every output pulse comes from an input value that counts system clock cycles.

Top module: `quad_clk_conv`

## Requirements
- R1: The resolution is chosen by `sel_x2_n` and `sel_x4`. When `sel_x2_n` is 0, two-edge mode applies whatever `sel_x4` holds. When `sel_x2_n` is 1 and `sel_x4` is 0, one-edge mode applies. When both pins are 1, four-edge mode applies.
- R2: Each input (phase A, phase B, index) passes through a two-flop synchronizer and then a stability counter. The filtered level changes only after the synchronized input has differed from it for `STABLE` consecutive clocks, where `STABLE` defaults to 4. A pulse of 2 clocks on an input therefore produces no output.
- R3: `dir` is 1 for forward motion, where A leads B, and 0 for reverse motion, where A lags B. It is updated on every legal filtered transition in every mode.
- R4: In four-edge mode, every legal transition of A or B gives one pulse. The pulse appears on `up_n` for forward motion and on `dn_n` for reverse motion.
- R5: In two-edge mode, only transitions of A give pulses. In one-edge mode, only a rising A during forward motion or a falling A during reverse motion gives a pulse.
- R6: After a qualifying edge, the output stays low for exactly `pulse_len` clocks. A `pulse_len` of 0 is treated as 1.
- R7: `idx_n` pulses low in two cases, whatever the mode: when A rises while the filtered index is 1 and B is 0, and when B falls while the filtered index is 1 and A is 1.
- R8: If A and B both change in the same filtered sample, the block produces no pulse on any output and leaves `dir` unchanged.
- R9: While `rst` is high, `up_n`, `dn_n` and `idx_n` are held at 1 and `dir` is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enc_a | input | 1 | Raw encoder phase A |
| enc_b | input | 1 | Raw encoder phase B |
| enc_idx | input | 1 | Raw encoder index track |
| sel_x2_n | input | 1 | Low selects two-edge mode |
| sel_x4 | input | 1 | With `sel_x2_n` high: 1 selects four-edge mode, 0 selects one-edge mode |
| pulse_len | input | PW_W | Output pulse width in clocks |
| up_n | output | 1 | Active-low forward pulse train |
| dn_n | output | 1 | Active-low reverse pulse train |
| dir | output | 1 | Direction level, 1 means forward |
| idx_n | output | 1 | Active-low index reference pulse |

## Verification
The assertions assume that A and B change no faster than the filter window allows. They also assume that `pulse_len` does not exceed the spacing between filtered edges. Under those conditions a pulse never starts while `dir` points the other way.

The stimulus holds every encoder level for 40 clocks, which is longer than the filter delay plus the longest pulse width used (20). It changes the index level and the mode pins only while the encoder is at rest. The only faster activity is a deliberate 2-clock glitch, and that glitch is meant to be rejected.

// File: rtl/qcc_pkg.sv
package qcc_pkg;
  typedef enum logic [1:0] {
    RES_X1 = 2'd0,
    RES_X2 = 2'd1,
    RES_X4 = 2'd2
  } qcc_res_e;

  function automatic qcc_res_e pick_res(input logic x2_n, input logic x4);
    if (!x2_n)   return RES_X2;
    else if (x4) return RES_X4;
    else         return RES_X1;
  endfunction
endpackage

// File: rtl/qcc_filter.sv
module qcc_filter #(
  parameter int STABLE = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(STABLE + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1   <= 1'b0;
      s2   <= 1'b0;
      filt <= 1'b0;
      cnt  <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 == filt) begin
        cnt <= '0;
      end else if (cnt == CW'(STABLE - 1)) begin
        filt <= s2;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: the filtered level only ever moves to the synchronized level
  a_r2_follow: assert property (@(posedge clk) disable iff (rst)
    (filt != $past(filt)) |-> ($past(s2) == filt));
  // R2: no change while synchronized input agrees with filtered level
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (s2 == filt) |=> (filt == $past(filt)));
endmodule

// File: rtl/qcc_decode.sv
module qcc_decode
  import qcc_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     fa,
  input  logic     fb,
  input  logic     fi,
  input  qcc_res_e res,
  output logic     dir,
  output logic     fire_up,
  output logic     fire_dn,
  output logic     fire_idx
);
  logic pa, pb;
  logic ach, bch, legal, fwd, qual, idx_hit;

  always_comb begin
    ach   = fa ^ pa;
    bch   = fb ^ pb;
    legal = ach ^ bch;
    fwd   = ach ? (fa ^ fb) : ~(fa ^ fb);
    unique case (res)
      RES_X4:  qual = 1'b1;
      RES_X2:  qual = ach;
      default: qual = ach && (fa == fwd);
    endcase
    idx_hit = fi && ((ach && fa && !fb) || (bch && !fb && fa));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pa       <= 1'b0;
      pb       <= 1'b0;
      dir      <= 1'b1;
      fire_up  <= 1'b0;
      fire_dn  <= 1'b0;
      fire_idx <= 1'b0;
    end else begin
      pa       <= fa;
      pb       <= fb;
      if (legal) dir <= fwd;
      fire_up  <= legal && qual && fwd;
      fire_dn  <= legal && qual && !fwd;
      fire_idx <= legal && idx_hit;
    end
  end

  // R8: a double change fires nothing
  a_r8_no_fire: assert property (@(posedge clk) disable iff (rst)
    (ach && bch) |=> (!fire_up && !fire_dn && !fire_idx));
  // R8: a double change leaves direction alone
  a_r8_dir_hold: assert property (@(posedge clk) disable iff (rst)
    (ach && bch) |=> (dir == $past(dir)));
  // R5: two-edge mode ignores B transitions
  a_r5_x2_no_b: assert property (@(posedge clk) disable iff (rst)
    (res == RES_X2 && bch && !ach) |=> (!fire_up && !fire_dn));
endmodule

// File: rtl/qcc_pulse.sv
module qcc_pulse #(
  parameter int PW_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic [PW_W-1:0] len,
  output logic            out_n
);
  logic [PW_W-1:0] rem, nxt, len_eff;

  always_comb begin
    len_eff = (len == '0) ? PW_W'(1) : len;
    if (fire)            nxt = len_eff;
    else if (rem != '0)  nxt = rem - 1'b1;
    else                 nxt = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem   <= '0;
      out_n <= 1'b1;
    end else begin
      rem   <= nxt;
      out_n <= (nxt == '0);
    end
  end

  // R6: a qualifying edge drives the output low on the next clock
  a_r6_start_low: assert property (@(posedge clk) disable iff (rst)
    fire |=> !out_n);
  // R9: reset releases the output high
  a_r9_rst_high: assert property (@(posedge clk)
    rst |=> out_n);
endmodule

// File: rtl/quad_clk_conv.sv
module quad_clk_conv
  import qcc_pkg::*;
#(
  parameter int STABLE = 4,
  parameter int PW_W   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            enc_a,
  input  logic            enc_b,
  input  logic            enc_idx,
  input  logic            sel_x2_n,
  input  logic            sel_x4,
  input  logic [PW_W-1:0] pulse_len,
  output logic            up_n,
  output logic            dn_n,
  output logic            dir,
  output logic            idx_n
);
  localparam int NCH = 3;

  logic [NCH-1:0] raw_v, filt_v, fire_v, out_v;
  qcc_res_e       res;

  assign raw_v = {enc_idx, enc_b, enc_a};
  assign res   = pick_res(sel_x2_n, sel_x4);

  for (genvar i = 0; i < NCH; i++) begin : g_filt
    qcc_filter #(.STABLE(STABLE)) u_filt (
      .clk (clk),
      .rst (rst),
      .raw (raw_v[i]),
      .filt(filt_v[i])
    );
  end

  qcc_decode u_dec (
    .clk     (clk),
    .rst     (rst),
    .fa      (filt_v[0]),
    .fb      (filt_v[1]),
    .fi      (filt_v[2]),
    .res     (res),
    .dir     (dir),
    .fire_up (fire_v[0]),
    .fire_dn (fire_v[1]),
    .fire_idx(fire_v[2])
  );

  for (genvar i = 0; i < NCH; i++) begin : g_pulse
    qcc_pulse #(.PW_W(PW_W)) u_pulse (
      .clk  (clk),
      .rst  (rst),
      .fire (fire_v[i]),
      .len  (pulse_len),
      .out_n(out_v[i])
    );
  end

  assign up_n  = out_v[0];
  assign dn_n  = out_v[1];
  assign idx_n = out_v[2];

  // R3: a forward pulse only starts while dir reports forward
  a_r3_up_dir: assert property (@(posedge clk) disable iff (rst)
    $fell(up_n) |-> dir);
  // R3: a reverse pulse only starts while dir reports reverse
  a_r3_dn_dir: assert property (@(posedge clk) disable iff (rst)
    $fell(dn_n) |-> !dir);
endmodule

// File: tb/tb_quad_clk_conv.sv
module tb_quad_clk_conv;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enc_a = 1'b0, enc_b = 1'b0, enc_idx = 1'b0;
  logic       sel_x2_n = 1'b1, sel_x4 = 1'b1;
  logic [7:0] pulse_len = 8'd3;
  logic       up_n, dn_n, dir, idx_n;

  always #10 clk = ~clk;

  quad_clk_conv dut (
    .clk(clk), .rst(rst), .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx),
    .sel_x2_n(sel_x2_n), .sel_x4(sel_x4), .pulse_len(pulse_len),
    .up_n(up_n), .dn_n(dn_n), .dir(dir), .idx_n(idx_n)
  );

  int total = 0, bad = 0;
  bit done = 0;
  int q_up[$], q_dn[$], q_ix[$];

  // model state
  bit ma = 0, mb = 0, mi = 0, mdir = 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int ch, input int w);
    case (ch)
      0: q_up.push_back(w);
      1: q_dn.push_back(w);
      default: q_ix.push_back(w);
    endcase
  endtask

  // monitor: measure each low pulse and compare to the scoreboard
  logic [2:0] prevo = 3'b111;
  int lowcnt [3] = '{0, 0, 0};
  always @(negedge clk) begin
    logic [2:0] o;
    o = {idx_n, dn_n, up_n};
    if (!rst) begin
      for (int ch = 0; ch < 3; ch++) begin
        if (!o[ch]) lowcnt[ch]++;
        else if (!prevo[ch]) begin
          int n;
          bit have;
          have = 0; n = 0;
          case (ch)
            0: if (q_up.size() > 0) begin n = q_up.pop_front(); have = 1; end
            1: if (q_dn.size() > 0) begin n = q_dn.pop_front(); have = 1; end
            default: if (q_ix.size() > 0) begin n = q_ix.pop_front(); have = 1; end
          endcase
          // R4 R5 R7: a pulse must have been expected on this channel
          check(have, (ch == 2) ? "R7 unexpected index pulse" : "R5 unexpected clock pulse", ch, -1);
          // R6: width equals programmed length
          if (have) check(lowcnt[ch] == n, "R6 pulse width", lowcnt[ch], n);
          lowcnt[ch] = 0;
        end
      end
    end
    prevo = o;
  end

  function automatic int res_mode();
    if (!sel_x2_n) return 2;
    return sel_x4 ? 4 : 1;
  endfunction

  task automatic step(input bit na, input bit nb);
    bit ach, bch, fwd, qual;
    int w;
    ach = (na != ma); bch = (nb != mb);
    w = (pulse_len == 0) ? 1 : int'(pulse_len);
    if (ach && bch) begin
      // R8: no pulse, direction kept
    end else if (ach || bch) begin
      fwd = ach ? (na != nb) : (na == nb);
      mdir = fwd;
      case (res_mode())
        4: qual = 1;                 // R4
        2: qual = ach;               // R5
        default: qual = ach && (na == fwd);
      endcase
      if (qual) push(fwd ? 0 : 1, w);
      if (mi && ((ach && na && !nb) || (bch && !nb && na))) push(2, w); // R7
    end
    ma = na; mb = nb;
    @(negedge clk);
    enc_a = na; enc_b = nb;
    repeat (40) @(negedge clk);
    check(dir == mdir, (ach && bch) ? "R8 dir after double change" : "R3 dir level",
          int'(dir), int'(mdir));
  endtask

  task automatic set_idx(input bit v);
    @(negedge clk);
    enc_idx = v; mi = v;
    repeat (12) @(negedge clk);
  endtask

  task automatic fwd_cycle();
    step(1, 0); step(1, 1); step(0, 1); step(0, 0);
  endtask

  task automatic rev_cycle();
    step(0, 1); step(1, 1); step(1, 0); step(0, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R9: reset state
    check(up_n == 1'b1,  "R9 up_n in reset",  int'(up_n), 1);
    check(dn_n == 1'b1,  "R9 dn_n in reset",  int'(dn_n), 1);
    check(idx_n == 1'b1, "R9 idx_n in reset", int'(idx_n), 1);
    check(dir == 1'b1,   "R9 dir in reset",   int'(dir), 1);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    // R4: four-edge mode, width 3
    sel_x2_n = 1; sel_x4 = 1; pulse_len = 8'd3;
    fwd_cycle();
    rev_cycle();

    // R7: index on A rise (B low) forward and B fall (A high) reverse
    set_idx(1);
    step(1, 0); step(1, 1); step(1, 0); step(0, 0);
    set_idx(0);

    // R1 R5: two-edge mode, sel_x4 ignored; width 0 acts as 1 (R6)
    sel_x2_n = 0; sel_x4 = 0; pulse_len = 8'd0;
    repeat (4) @(negedge clk);
    fwd_cycle();
    sel_x4 = 1;
    repeat (4) @(negedge clk);
    rev_cycle();

    // R1 R5: one-edge mode, long pulses
    sel_x2_n = 1; sel_x4 = 0; pulse_len = 8'd20;
    repeat (4) @(negedge clk);
    fwd_cycle();
    rev_cycle();

    // R8: simultaneous change of A and B in four-edge mode
    sel_x4 = 1; pulse_len = 8'd5;
    repeat (4) @(negedge clk);
    step(1, 0);
    step(0, 1);
    step(0, 0);

    // R2: a 2-clock glitch on A is rejected
    @(negedge clk); enc_a = 1;
    repeat (2) @(negedge clk); enc_a = 0;
    repeat (40) @(negedge clk);
    check(dir == mdir, "R2 dir after glitch", int'(dir), int'(mdir));

    // scoreboard drained: every expected pulse appeared (R4 R5 R7)
    check(q_up.size() == 0, "R4 missing up pulses",    q_up.size(), 0);
    check(q_dn.size() == 0, "R4 missing down pulses",  q_dn.size(), 0);
    check(q_ix.size() == 0, "R7 missing index pulses", q_ix.size(), 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule